// File: doc/BRIEF.md
# Watchdog and Interval Timer with Keyed Feed

This block guards a small processor against runaway software, or acts as a plain periodic timer. A source tick is chosen either every clock cycle, gated off while the processor is in power-down, or an external slow-oscillator tick enable. That tick passes through a fixed divide-by-32 stage and then a 12-bit prescaler. One of eight prescaler taps decrements an 8-bit down counter. When the counter is at zero and receives one more decrement, that is an underflow, and the counter starts again from an 8-bit reload value.

Software reaches the block through a single-cycle register port with four addresses. Address 0 is the control register, address 1 is the reload register, and addresses 2 and 3 are the two feed keys. Two bytes written back to back, 0xA5 to address 2 and then 0x5A to address 3, restart the timebase and load the counter. Writes to the control register go into a shadow copy. The active settings pick up that copy only when the next feed pair completes.

A sticky arm input puts the block into watchdog mode. Only a power-on reset takes it out again. In watchdog mode, an underflow or any breach of the feed protocol gives a one-cycle system-reset request. In interval mode the same underflow sets a time-out flag and drives the interrupt output instead.

Top module: `wdt_feed_timer`

## Requirements
- R1: After a power-on reset:
  - the control register reads 0x00;
  - the reload register reads 0xFF;
  - the counter (read address 2) reads 0xFF;
  - `wd_rst_req` and `irq` are low.
- R2: Writing 0xA5 to address 2 and then 0x5A to address 3 on two consecutive write cycles does three things:
  - it loads the counter from the reload register;
  - it clears the divider and the prescaler;
  - when it completes, it clears the feed state machine.

  Writing the reload register alone does not change the counter.
- R3: Any of the following is a feed violation:
  - a value other than 0xA5 written to address 2;
  - a write to address 3 that does not come straight after a valid first key;
  - any write other than 0x5A to address 3 in the cycle after a valid first key.

  In watchdog mode, each violation gives exactly one cycle of `wd_rst_req`. In interval mode it gives none. A violation returns the feed state machine to idle, and the violating write still updates its own register.
- R4: The control register has these fields:

  | Bits | Field | Meaning |
  |------|-------|---------|
  | [2:0] | tap select | prescaler tap |
  | 3 | run | counting enable |
  | 4 | time-out flag | sticky flag |
  | 5 | source | 1 = clock, 0 = oscillator tick |
  | 7 | enable | read-only watchdog enable |

  A control write changes only the shadow copy, so readback keeps showing the active value until a feed pair completes. The next write after a control write must be a valid first key. Otherwise it is a violation, the shadow is discarded and, in watchdog mode, a reset request follows.
- R5: With run set, the counter decrements once every 32 × 2^(p+5) source ticks, where p is the tap select. With run clear it holds its value.
- R6: In watchdog mode, an underflow gives one cycle of `wd_rst_req` and reloads the counter. Feeding before an underflow prevents the request.
- R7: In interval mode, an underflow sets the time-out flag, raises `irq` and reloads the counter, with no reset request. Writing 0 to bit 4 of the control register clears the flag at once. The flag is never set in watchdog mode.
- R8: With the clock selected as the source, asserting `pd` stops all counting. With the oscillator tick selected, `pd` has no effect.
- R9: `wd_arm` sets the watchdog enable, which reads back as control bit 7. `sys_rst` returns every other register to its reset value but leaves the enable set. Only `por` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high, clears everything |
| sys_rst | input | 1 | Synchronous system reset, active high, keeps watchdog enable |
| wd_arm | input | 1 | Sets the sticky watchdog enable |
| pd | input | 1 | Processor power-down indication |
| osc_tick | input | 1 | Slow-oscillator tick enable |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Write address: 0 control, 1 reload, 2 first key, 3 second key |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 reload, 2 counter, 3 reads zero |
| rd_data | output | 8 | Registered read data, valid the cycle after the address |
| wd_rst_req | output | 1 | One-cycle system-reset request |
| irq | output | 1 | Interval time-out interrupt, follows the flag in interval mode |

## Verification
The properties assume the following about the inputs:
- `por` is high from time zero.
- At most one register write arrives per cycle, because a write counts as both feed keys only across two successive strobes.
- Tick enables are plain one-cycle qualifiers of the single clock.

The stimulus follows these assumptions:
- Every write is issued at a falling edge and held for exactly one cycle.
- Feed pairs are issued on back-to-back cycles.
- The run, source and power-down inputs change only while the divider is idle or freshly cleared by a feed.

Timing checks are placed a few hundred cycles away from each expected decrement edge, so they do not depend on the exact cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [1:0] {
    A_CTL = 2'd0,
    A_RLD = 2'd1,
    A_FD1 = 2'd2,
    A_FD2 = 2'd3
  } reg_addr_e;

  typedef enum logic {
    FS_IDLE  = 1'b0,
    FS_ARMED = 1'b1
  } feed_st_e;

  localparam logic [DATA_W-1:0] FEED_KEY1 = 8'hA5;
  localparam logic [DATA_W-1:0] FEED_KEY2 = 8'h5A;

  localparam int unsigned CB_SEL = 0;
  localparam int unsigned CB_RUN = 3;
  localparam int unsigned CB_TOF = 4;
  localparam int unsigned CB_SRC = 5;
  localparam int unsigned CB_EN  = 7;
endpackage

// File: rtl/wdt_feed_fsm.sv
module wdt_feed_fsm
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              feed_ok,
  output logic              viol,
  output logic              pend_q
);
  feed_st_e st_q, st_d;
  logic     pend_d;
  reg_addr_e adr;

  assign adr = reg_addr_e'(wr_addr);

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    feed_ok = 1'b0;
    viol    = 1'b0;
    if (wr_en) begin
      unique case (st_q)
        FS_IDLE: begin
          if (adr == A_FD1 && wr_data == FEED_KEY1) st_d = FS_ARMED;
          else if (adr == A_FD1 || adr == A_FD2)    viol = 1'b1;
          else if (pend_q)                          viol = 1'b1;
          else if (adr == A_CTL)                    pend_d = 1'b1;
        end
        FS_ARMED: begin
          if (adr == A_FD2 && wr_data == FEED_KEY2) begin
            feed_ok = 1'b1;
            st_d    = FS_IDLE;
            pend_d  = 1'b0;
          end else begin
            viol = 1'b1;
          end
        end
        default: st_d = FS_IDLE;
      endcase
    end
    if (viol) begin
      st_d   = FS_IDLE;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FS_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  // R3: whatever follows a first key, the machine leaves the armed state
  p_armed_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == FS_ARMED && wr_en) |=> (st_q == FS_IDLE));

  // R4: a completed feed consumes any pending shadow
  p_pend_clear_r4: assert property (@(posedge clk) disable iff (rst)
    feed_ok |=> !pend_q);
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned PRE_W   = 12,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned TAP_OFS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             use_pclk,
  input  logic             pd,
  input  logic             osc_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             dec
);
  localparam int unsigned NTAP = 1 << SEL_W;

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic             src, step, div_wrap;
  logic [NTAP-1:0]  tap_hit;

  assign src      = use_pclk ? !pd : osc_tick;
  assign step     = run & src;
  assign div_wrap = step & (&div_q);

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap_hit[k] = &pre_q[k+TAP_OFS-1:0];
  end

  assign dec = div_wrap & tap_hit[sel];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (step) begin
      div_q <= div_q + 1'b1;
      if (div_wrap) pre_q <= pre_q + 1'b1;
    end
  end

  // R8: clock source with power-down freezes the timebase
  p_pd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (use_pclk && pd && !clr) |=> ($stable(div_q) && $stable(pre_q)));
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uf
);
  assign uf = dec && (cnt_q == '0) && !load;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '1;
    else if (load)          cnt_q <= load_val;
    else if (dec) begin
      if (cnt_q == '0)      cnt_q <= load_val;
      else                  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2: a feed loads the reload value
  p_feed_load_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));

  // R5: a tap step lowers the count by one
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6: underflow restarts from the reload value
  p_uf_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && cnt_q == '0) |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/wdt_feed_timer.sv
module wdt_feed_timer
  import wdt_pkg::*;
#(
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned PRE_W   = 12,
  parameter int unsigned TAP_OFS = 5
) (
  input  logic              clk,
  input  logic              por,
  input  logic              sys_rst,
  input  logic              wd_arm,
  input  logic              pd,
  input  logic              osc_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wd_rst_req,
  output logic              irq
);
  logic              rst_all;
  logic              en_q, tof_q, run_q, src_q, req_q;
  logic [SEL_W-1:0]  sel_q, sh_sel_q;
  logic              sh_run_q, sh_src_q;
  logic [DATA_W-1:0] rld_q, rd_q, cnt_q, ctl_view;
  logic              feed_ok, viol, pend_q, dec, uf, ctl_wr, rld_wr;

  assign rst_all = por | sys_rst;
  assign ctl_wr  = wr_en && reg_addr_e'(wr_addr) == A_CTL;
  assign rld_wr  = wr_en && reg_addr_e'(wr_addr) == A_RLD;

  wdt_feed_fsm u_fsm (
    .clk     (clk),
    .rst     (rst_all),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .feed_ok (feed_ok),
    .viol    (viol),
    .pend_q  (pend_q)
  );

  wdt_timebase #(
    .DIV_W   (DIV_W),
    .PRE_W   (PRE_W),
    .SEL_W   (SEL_W),
    .TAP_OFS (TAP_OFS)
  ) u_tb (
    .clk      (clk),
    .rst      (rst_all),
    .clr      (feed_ok),
    .run      (run_q),
    .use_pclk (src_q),
    .pd       (pd),
    .osc_tick (osc_tick),
    .sel      (sel_q),
    .dec      (dec)
  );

  wdt_downcount #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst_all),
    .load     (feed_ok),
    .load_val (rld_q),
    .dec      (dec),
    .cnt_q    (cnt_q),
    .uf       (uf)
  );

  always_ff @(posedge clk) begin
    if (por)         en_q <= 1'b0;
    else if (wd_arm) en_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      sel_q    <= '0;
      run_q    <= 1'b0;
      src_q    <= 1'b0;
      sh_sel_q <= '0;
      sh_run_q <= 1'b0;
      sh_src_q <= 1'b0;
      rld_q    <= '1;
      tof_q    <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      if (ctl_wr) begin
        sh_sel_q <= wr_data[CB_SEL +: SEL_W];
        sh_run_q <= wr_data[CB_RUN];
        sh_src_q <= wr_data[CB_SRC];
      end
      if (feed_ok && pend_q) begin
        sel_q <= sh_sel_q;
        run_q <= sh_run_q;
        src_q <= sh_src_q;
      end
      if (rld_wr) rld_q <= wr_data;
      if (uf && !en_q)                     tof_q <= 1'b1;
      else if (ctl_wr && !wr_data[CB_TOF]) tof_q <= 1'b0;
      req_q <= en_q && (viol || uf);
    end
  end

  always_comb begin
    ctl_view                     = '0;
    ctl_view[CB_SEL +: SEL_W]    = sel_q;
    ctl_view[CB_RUN]             = run_q;
    ctl_view[CB_TOF]             = tof_q;
    ctl_view[CB_SRC]             = src_q;
    ctl_view[CB_EN]              = en_q;
  end

  always_ff @(posedge clk) begin
    if (por) rd_q <= '0;
    else begin
      unique case (reg_addr_e'(rd_addr))
        A_CTL:   rd_q <= ctl_view;
        A_RLD:   rd_q <= rld_q;
        A_FD1:   rd_q <= cnt_q;
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data    = rd_q;
  assign wd_rst_req = req_q;
  assign irq        = tof_q && !en_q;

  // R3: a protocol breach in watchdog mode requests a reset
  p_viol_req_r3: assert property (@(posedge clk) disable iff (rst_all)
    (en_q && viol) |=> wd_rst_req);

  // R4: active settings move only on a feed that consumes a shadow
  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (rst_all)
    !(feed_ok && pend_q) |=> ($stable(sel_q) && $stable(run_q) && $stable(src_q)));

  // R7: interval mode never requests a reset
  p_no_req_interval_r7: assert property (@(posedge clk) disable iff (rst_all)
    !en_q |-> !wd_rst_req);

  // R7: interval underflow sets the flag
  p_uf_flag_r7: assert property (@(posedge clk) disable iff (rst_all)
    (uf && !en_q) |=> tof_q);

  // R9: enable is sticky until power-on reset
  p_en_sticky_r9: assert property (@(posedge clk) disable iff (por)
    en_q |=> en_q);
endmodule

// File: tb/wdt_feed_timer_tb.sv
module wdt_feed_timer_tb;
  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       sys_rst = 1'b0;
  logic       wd_arm = 1'b0;
  logic       pd = 1'b0;
  logic       osc_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wd_rst_req, irq;

  int n_chk = 0;
  int n_bad = 0;
  int rst_cnt = 0;
  logic mon_arm = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  wdt_feed_timer u_dut (
    .clk(clk), .por(por), .sys_rst(sys_rst), .wd_arm(wd_arm), .pd(pd),
    .osc_tick(osc_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wd_rst_req(wd_rst_req), .irq(irq)
  );

  always @(posedge clk) begin
    #1;
    if (wd_rst_req) rst_cnt++;
  end

  // monitor: compare registered read data against queued expectations
  always @(posedge clk) begin
    if (mon_arm) begin
      logic [7:0] e;
      string t;
      #2;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rd_data !== e) begin
        n_bad++;
        $display("FAIL %s: read got %02h expected %02h", t, rd_data, e);
      end
    end
  end

  task automatic check(input string t, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string t);
    rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    mon_arm = 1'b1;
    @(negedge clk);
    mon_arm = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    finish_run();
  end

  initial begin
    idle(3);
    por = 1'b0;
    idle(1);
    // R1 reset state
    rd_chk(2'd0, 8'h00, "R1 ctl");
    rd_chk(2'd1, 8'hFF, "R1 reload");
    rd_chk(2'd2, 8'hFF, "R1 counter");
    check("R1 irq", int'(irq), 0);
    check("R1 req", rst_cnt, 0);

    // R2 reload write alone does not load; feed does
    wr(2'd1, 8'h05);
    rd_chk(2'd2, 8'hFF, "R2 no load before feed");
    feed();
    rd_chk(2'd2, 8'h05, "R2 counter loaded");

    // R4 shadowed control, clock source, run, tap 1
    wr(2'd0, 8'h29);
    rd_chk(2'd0, 8'h00, "R4 shadow not active");
    feed();
    rd_chk(2'd0, 8'h29, "R4 shadow applied");
    idle(1795);
    rd_chk(2'd2, 8'h05, "R5 tap1 before step");
    idle(400);
    rd_chk(2'd2, 8'h04, "R5 tap1 after step");

    // tap 0
    wr(2'd0, 8'h28);
    feed();
    idle(900);
    rd_chk(2'd2, 8'h05, "R5 tap0 before step");
    idle(200);
    rd_chk(2'd2, 8'h04, "R5 tap0 after step");

    // R7 interval underflow around edge 6144 after feed
    idle(5190);
    rd_chk(2'd0, 8'h38, "R7 flag set");
    check("R7 irq high", int'(irq), 1);
    check("R7 no reset request", rst_cnt, 0);
    rd_chk(2'd2, 8'h05, "R7 reloaded");
    wr(2'd0, 8'h28);
    rd_chk(2'd0, 8'h28, "R7 flag cleared");
    check("R7 irq low", int'(irq), 0);

    // R3 interval mode violation: no request
    wr(2'd2, 8'h00);
    idle(2);
    check("R3 interval no request", rst_cnt, 0);

    // R8 power-down with clock source
    pd = 1'b1;
    feed();
    idle(1200);
    rd_chk(2'd2, 8'h05, "R8 clock source frozen");
    pd = 1'b0;

    // R8 oscillator source ignores power-down
    wr(2'd0, 8'h08);
    feed();
    pd = 1'b1;
    idle(1200);
    rd_chk(2'd2, 8'h05, "R8 osc idle no ticks");
    rd_chk(2'd0, 8'h08, "R8 osc source active");
    osc_tick = 1'b1;
    idle(1100);
    rd_chk(2'd2, 8'h04, "R8 osc counts in power-down");
    osc_tick = 1'b0;
    pd = 1'b0;

    // R5 run clear holds
    wr(2'd0, 8'h20);
    feed();
    idle(1200);
    rd_chk(2'd2, 8'h05, "R5 run clear holds");

    // R9 arm and system reset
    wd_arm = 1'b1;
    idle(1);
    wd_arm = 1'b0;
    rd_chk(2'd0, 8'hA0, "R9 enable set");
    sys_rst = 1'b1;
    idle(1);
    sys_rst = 1'b0;
    rd_chk(2'd0, 8'h80, "R9 enable survives system reset");
    rd_chk(2'd1, 8'hFF, "R9 reload reset by system reset");
    check("R9 no request", rst_cnt, 0);

    // R3 violations in watchdog mode
    wr(2'd2, 8'h11);
    idle(2);
    check("R3 wrong first key", rst_cnt, 1);
    wr(2'd2, 8'hA5);
    wr(2'd1, 8'h01);
    idle(2);
    check("R3 write between keys", rst_cnt, 2);
    wr(2'd3, 8'h5A);
    idle(2);
    check("R3 lone second key", rst_cnt, 3);

    // R4 control write not followed by feed
    wr(2'd0, 8'h28);
    wr(2'd1, 8'h01);
    idle(2);
    check("R4 control without feed", rst_cnt, 4);
    rd_chk(2'd0, 8'h80, "R4 shadow discarded");
    wr(2'd0, 8'h28);
    feed();
    idle(2);
    check("R4 proper sequence no request", rst_cnt, 4);
    rd_chk(2'd0, 8'hA8, "R4 watchdog shadow applied");
    rd_chk(2'd2, 8'h01, "R2 counter loaded from reload");

    // R6 keep-alive then starve
    for (int i = 0; i < 3; i++) begin
      idle(1500);
      feed();
    end
    check("R6 fed in time", rst_cnt, 4);
    idle(2200);
    check("R6 underflow request", rst_cnt, 5);
    rd_chk(2'd0, 8'hA8, "R7 no flag in watchdog mode");
    check("R7 irq low in watchdog mode", int'(irq), 0);

    // R9 power-on reset clears enable
    por = 1'b1;
    idle(1);
    por = 1'b0;
    rd_chk(2'd0, 8'h00, "R9 power-on clears enable");
    idle(3);
    finish_run();
  end
endmodule